// File: doc/BRIEF.md
# Clock Root Configuration Commit Interface

This block is the software-facing register front end of a clock root generator. Software programs a staged copy of the root configuration: a configuration word holding the pre-divider, source select and counter mode, plus the M, N and D values of the fractional counter. None of those writes reaches the clock hardware directly. Only the active copy, which this block drives out as plain fields, feeds the divider datapath and the source switch, both of which sit outside the block.

To apply a new setting, software sets the update bit in the command word. After a fixed, short number of cycles the whole staged set is copied into the active set on a single clock edge, and the update bit drops. Software polls that bit to learn that the new configuration has taken effect. Per-register change flags show which staged values differ from what was last committed. The command word also carries a root enable, which takes effect at once, and a read-only status bit that reports whether the root output is stopped.

Top module: `clk_root_cfg`

## Requirements
- R1: After reset the staged and active values are all zero, root enable is 0, the update bit and all change flags read 0, and command bit 31 reads 1.
- R2: Writes to the configuration word (byte offset 0x4), M (0x8), N (0xC) and D (0x10) update only the staged copy. The staged copy reads back the written value masked to its implemented bits: configuration bits [PREDIV_W-1:0] (pre-divider), [10:8] (source) and [13:12] (mode), and bits [MND_W-1:0] of M, N and D. All other bits read 0. The active outputs do not change on such a write.
- R3: Command bits 4, 5, 6 and 7 are the change flags for the configuration word, N, M and D in that order. A flag is set when its register is written with a masked value that differs from the staged value. A write of an equal masked value leaves the flag unchanged.
- R4: Writing 1 to command bit 0 (byte offset 0x0) while no commit is pending starts a commit. Bit 0 then reads 1 for exactly COMMIT_CYCLES cycles and then clears itself. All active outputs take the staged values on the same edge at which the bit clears.
- R5: All change flags clear on the edge that completes a commit. A shadow write that lands on that same edge is not part of the commit: its value stays staged and its flag is set.
- R6: While a commit is pending, writing 0 to bit 0 does not cancel it, and writing 1 does not restart it. The completion cycle stays unchanged.
- R7: Command bit 1 is a read/write root enable that drives root_en_o directly, with no commit. Command bit 31 reads 0 only while root enable is 1 and clk_running_i is 1.
- R8: Writes to the command word do not change the change flags or bit 31. Writes to any address other than the five register offsets are ignored, and reads from such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per write |
| bus_wr | input | 1 | 1 for a write when bus_sel is high |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| clk_running_i | input | 1 | High while the root output clock toggles |
| root_en_o | output | 1 | Root enable to the clock gate |
| act_prediv_o | output | PREDIV_W | Active half-integer pre-divider |
| act_src_o | output | 3 | Active source select |
| act_mode_o | output | 2 | Active counter mode |
| act_m_o | output | MND_W | Active M value |
| act_n_o | output | MND_W | Active N value |
| act_d_o | output | MND_W | Active D value |

## Verification
A corrupted commit counter shows up within COMMIT_CYCLES+1 cycles. Either the update bit stays high longer or shorter than specified, or the active fields change on an edge other than the one at which the bit falls. The bench therefore counts cycles from the start write to the first clear read, and checks the active outputs both one cycle before and at that point. A wrong change flag is visible on the very next command read. It is exercised with equal-value writes, writes that differ only in unimplemented bits, command writes that try to clear the flags, and a shadow write timed to land on the completion edge. A staged value that leaks into the active set early is caught by the active-output checks made while a commit is pending.

// File: rtl/clk_root_pkg.sv
package clk_root_pkg;

    // register byte offsets (software contract)
    localparam logic [31:0] OFS_CMD = 32'h00;
    localparam logic [31:0] OFS_CFG = 32'h04;
    localparam logic [31:0] OFS_M   = 32'h08;
    localparam logic [31:0] OFS_N   = 32'h0C;
    localparam logic [31:0] OFS_D   = 32'h10;

    // staged-register slots; order matches the change-flag bits in the command word
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_CFG  = 0;
    localparam int SLOT_N    = 1;
    localparam int SLOT_M    = 2;
    localparam int SLOT_D    = 3;

    // command word bit positions
    localparam int CMD_UPD_BIT   = 0;
    localparam int CMD_EN_BIT    = 1;
    localparam int CMD_DIRTY_LSB = 4;
    localparam int CMD_OFF_BIT   = 31;

    // configuration word fields
    localparam int SRC_LSB  = 8;
    localparam int SRC_W    = 3;
    localparam int MODE_LSB = 12;
    localparam int MODE_W   = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_CFG,
        SEL_M,
        SEL_N,
        SEL_D
    } reg_sel_e;

    function automatic logic [31:0] low_mask(input int unsigned w);
        logic [31:0] m;
        if (w >= 32) m = '1;
        else         m = (32'd1 << w) - 32'd1;
        return m;
    endfunction

    function automatic logic [31:0] cfg_field_mask(input int unsigned prediv_w);
        logic [31:0] m;
        m = low_mask(prediv_w);
        m[SRC_LSB +: SRC_W]   = '1;
        m[MODE_LSB +: MODE_W] = '1;
        return m;
    endfunction

endpackage

// File: rtl/clk_root_commit.sv
module clk_root_commit #(
    parameter int unsigned COMMIT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic pending_o,
    output logic done_o
);

    localparam int unsigned CNT_W = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(COMMIT_CYCLES - 1);

    typedef struct packed {
        logic             pend;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_w;

    assign last_w = seq_q.pend && (seq_q.cnt == LAST);

    always_comb begin
        seq_d = seq_q;
        if (last_w) begin
            seq_d.pend = 1'b0;
            seq_d.cnt  = '0;
        end else if (seq_q.pend) begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end else if (start_i) begin
            seq_d.pend = 1'b1;
            seq_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign pending_o = seq_q.pend;
    assign done_o    = last_w;

    AST_COMMIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.cnt <= LAST); // R4
    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !pending_o); // R4
    AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_o |-> seq_q.cnt == '0); // R4
    AST_NO_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o && !done_o |=> pending_o); // R6

endmodule

// File: rtl/clk_root_shadow.sv
module clk_root_shadow
    import clk_root_pkg::*;
#(
    parameter int unsigned PREDIV_W = 5,
    parameter int unsigned MND_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SLOTS-1:0]        wr_en_i,
    input  logic [31:0]                 wdata_i,
    input  logic                        commit_i,
    output logic [NUM_SLOTS-1:0][31:0]  shadow_o,
    output logic [NUM_SLOTS-1:0]        dirty_o
);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam logic [31:0] MASK = (i == SLOT_CFG) ? cfg_field_mask(PREDIV_W)
                                                       : low_mask(MND_W);
        typedef struct packed {
            logic [31:0] val;
            logic        dirty;
        } slot_t;

        slot_t       s_d, s_q;
        logic [31:0] new_val;
        logic        changes;

        always_comb begin
            s_d     = s_q;
            new_val = wdata_i & MASK;
            changes = wr_en_i[i] && (new_val != s_q.val);
            if (wr_en_i[i]) s_d.val = new_val;
            // a differing write on the completion edge keeps its flag
            if (changes)       s_d.dirty = 1'b1;
            else if (commit_i) s_d.dirty = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign shadow_o[i] = s_q.val;
        assign dirty_o[i]  = s_q.dirty;

        AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en_i[i] |=> $stable(shadow_o[i])); // R2
        AST_DIRTY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_i[i] && ((wdata_i & MASK) != shadow_o[i]) |=> dirty_o[i]); // R3
        AST_SAME_VALUE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_i[i] && ((wdata_i & MASK) == shadow_o[i]) && !dirty_o[i] |=> !dirty_o[i]); // R3
    end

endmodule

// File: rtl/clk_root_cfg.sv
module clk_root_cfg
    import clk_root_pkg::*;
#(
    parameter int unsigned ADDR_W        = 5,
    parameter int unsigned PREDIV_W      = 5,
    parameter int unsigned MND_W         = 8,
    parameter int unsigned COMMIT_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                clk_running_i,
    output logic                root_en_o,
    output logic [PREDIV_W-1:0] act_prediv_o,
    output logic [SRC_W-1:0]    act_src_o,
    output logic [MODE_W-1:0]   act_mode_o,
    output logic [MND_W-1:0]    act_m_o,
    output logic [MND_W-1:0]    act_n_o,
    output logic [MND_W-1:0]    act_d_o
);

    typedef struct packed {
        logic                root_en;
        logic [PREDIV_W-1:0] prediv;
        logic [SRC_W-1:0]    src;
        logic [MODE_W-1:0]   mode;
        logic [MND_W-1:0]    m;
        logic [MND_W-1:0]    n;
        logic [MND_W-1:0]    d;
    } ctl_t;

    ctl_t                       ctl_d, ctl_q;
    reg_sel_e                   sel_w;
    logic [31:0]                addr_ext;
    logic                       wr_w;
    logic [NUM_SLOTS-1:0]       wr_slot;
    logic                       start_w;
    logic                       pending_w;
    logic                       done_w;
    logic [NUM_SLOTS-1:0][31:0] shadow_w;
    logic [NUM_SLOTS-1:0]       dirty_w;
    logic                       root_off_w;
    logic [31:0]                cmd_rd;

    // address decode
    assign addr_ext = 32'(bus_addr);
    always_comb begin
        case (addr_ext)
            OFS_CMD: sel_w = SEL_CMD;
            OFS_CFG: sel_w = SEL_CFG;
            OFS_M:   sel_w = SEL_M;
            OFS_N:   sel_w = SEL_N;
            OFS_D:   sel_w = SEL_D;
            default: sel_w = SEL_NONE;
        endcase
    end

    assign wr_w = bus_sel && bus_wr;

    always_comb begin
        wr_slot           = '0;
        wr_slot[SLOT_CFG] = wr_w && (sel_w == SEL_CFG);
        wr_slot[SLOT_N]   = wr_w && (sel_w == SEL_N);
        wr_slot[SLOT_M]   = wr_w && (sel_w == SEL_M);
        wr_slot[SLOT_D]   = wr_w && (sel_w == SEL_D);
    end

    assign start_w = wr_w && (sel_w == SEL_CMD) && bus_wdata[CMD_UPD_BIT] && !pending_w;

    clk_root_shadow #(
        .PREDIV_W (PREDIV_W),
        .MND_W    (MND_W)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_slot),
        .wdata_i  (bus_wdata),
        .commit_i (done_w),
        .shadow_o (shadow_w),
        .dirty_o  (dirty_w)
    );

    clk_root_commit #(
        .COMMIT_CYCLES (COMMIT_CYCLES)
    ) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_w),
        .pending_o (pending_w),
        .done_o    (done_w)
    );

    // next-state for enable and active set
    always_comb begin
        ctl_d = ctl_q;
        if (wr_w && (sel_w == SEL_CMD)) ctl_d.root_en = bus_wdata[CMD_EN_BIT];
        if (done_w) begin
            ctl_d.prediv = shadow_w[SLOT_CFG][PREDIV_W-1:0];
            ctl_d.src    = shadow_w[SLOT_CFG][SRC_LSB +: SRC_W];
            ctl_d.mode   = shadow_w[SLOT_CFG][MODE_LSB +: MODE_W];
            ctl_d.m      = shadow_w[SLOT_M][MND_W-1:0];
            ctl_d.n      = shadow_w[SLOT_N][MND_W-1:0];
            ctl_d.d      = shadow_w[SLOT_D][MND_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign root_off_w = !(ctl_q.root_en && clk_running_i);

    always_comb begin
        cmd_rd                                = '0;
        cmd_rd[CMD_UPD_BIT]                   = pending_w;
        cmd_rd[CMD_EN_BIT]                    = ctl_q.root_en;
        cmd_rd[CMD_DIRTY_LSB +: NUM_SLOTS]    = dirty_w;
        cmd_rd[CMD_OFF_BIT]                   = root_off_w;
    end

    always_comb begin
        case (sel_w)
            SEL_CMD: bus_rdata = cmd_rd;
            SEL_CFG: bus_rdata = shadow_w[SLOT_CFG];
            SEL_M:   bus_rdata = shadow_w[SLOT_M];
            SEL_N:   bus_rdata = shadow_w[SLOT_N];
            SEL_D:   bus_rdata = shadow_w[SLOT_D];
            default: bus_rdata = '0;
        endcase
    end

    assign root_en_o    = ctl_q.root_en;
    assign act_prediv_o = ctl_q.prediv;
    assign act_src_o    = ctl_q.src;
    assign act_mode_o   = ctl_q.mode;
    assign act_m_o      = ctl_q.m;
    assign act_n_o      = ctl_q.n;
    assign act_d_o      = ctl_q.d;

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_w |=> $stable(act_prediv_o) && $stable(act_src_o) && $stable(act_mode_o)
                    && $stable(act_m_o) && $stable(act_n_o) && $stable(act_d_o)); // R2
    AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        done_w |=> act_m_o == $past(shadow_w[SLOT_M][MND_W-1:0])
               && act_n_o == $past(shadow_w[SLOT_N][MND_W-1:0])
               && act_d_o == $past(shadow_w[SLOT_D][MND_W-1:0])
               && act_src_o == $past(shadow_w[SLOT_CFG][SRC_LSB +: SRC_W])); // R4
    AST_DIRTY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        done_w && (wr_slot == '0) |=> dirty_w == '0); // R5
    AST_CMD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_w && (sel_w == SEL_CMD) && !done_w |=> $stable(dirty_w)); // R8

endmodule

// File: tb/test_clk_root_cfg.sv
module test_clk_root_cfg;
    import clk_root_pkg::*;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned PREDIV_W = 5;
    localparam int unsigned MND_W = 8;
    localparam int unsigned COMMIT_CYCLES = 4;

    localparam logic [31:0] CFG_MASK = 32'h0000_371F; // prediv[4:0], src[10:8], mode[13:12]
    localparam logic [31:0] MND_MASK = 32'h0000_00FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0;
    logic bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic clk_running_i = 1'b1;
    logic root_en_o;
    logic [PREDIV_W-1:0] act_prediv_o;
    logic [2:0] act_src_o;
    logic [1:0] act_mode_o;
    logic [MND_W-1:0] act_m_o, act_n_o, act_d_o;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    clk_root_cfg #(
        .ADDR_W(ADDR_W), .PREDIV_W(PREDIV_W), .MND_W(MND_W), .COMMIT_CYCLES(COMMIT_CYCLES)
    ) i_clk_root_cfg (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clk_running_i(clk_running_i), .root_en_o(root_en_o),
        .act_prediv_o(act_prediv_o), .act_src_o(act_src_o), .act_mode_o(act_mode_o),
        .act_m_o(act_m_o), .act_n_o(act_n_o), .act_d_o(act_d_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr[ADDR_W-1:0]; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] addr, output logic [31:0] data);
        bus_addr = addr[ADDR_W-1:0];
        #1;
        data = bus_rdata;
    endtask

    function automatic logic [31:0] act_word();
        return {1'b0, act_prediv_o, act_src_o, act_mode_o, act_m_o, act_n_o, act_d_o};
    endfunction

    function automatic logic [31:0] mk_act(input logic [4:0] p, input logic [2:0] s,
        input logic [1:0] md, input logic [7:0] m, input logic [7:0] n, input logic [7:0] d);
        return {1'b0, p, s, md, m, n, d};
    endfunction

    // polls until the update bit reads 0; returns cycles elapsed since start
    task automatic wait_clear(input int start_cyc, output int elapsed);
        logic [31:0] r;
        elapsed = -1;
        for (int k = 0; k < 100; k++) begin
            bus_read(OFS_CMD, r);
            if (r[0] == 1'b0) begin
                elapsed = cyc - start_cyc;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] r;
        bus_read(OFS_CMD, r); check("R1 command word after reset", r, 32'h8000_0000);
        bus_read(OFS_CFG, r); check("R1 cfg shadow after reset", r, 0);
        bus_read(OFS_M, r);   check("R1 M shadow after reset", r, 0);
        bus_read(OFS_N, r);   check("R1 N shadow after reset", r, 0);
        bus_read(OFS_D, r);   check("R1 D shadow after reset", r, 0);
        check("R1 active outputs after reset", act_word(), 0);
        check("R1 root enable after reset", 32'(root_en_o), 0);
    endtask

    task automatic t_shadow();
        logic [31:0] r;
        bus_write(OFS_CFG, 32'hFFFF_FFFF);
        bus_read(OFS_CFG, r); check("R2 cfg masked readback", r, 32'hFFFF_FFFF & CFG_MASK);
        bus_read(OFS_CMD, r); check("R3 cfg flag is bit 4", r, 32'h8000_0010);
        bus_write(OFS_M, 32'h0000_1234);
        bus_read(OFS_M, r);   check("R2 M masked readback", r, 32'h1234 & MND_MASK);
        bus_read(OFS_CMD, r); check("R3 M flag is bit 6", r, 32'h8000_0050);
        bus_write(OFS_N, 32'h0000_ABCD);
        bus_read(OFS_N, r);   check("R2 N masked readback", r, 32'hABCD & MND_MASK);
        bus_read(OFS_CMD, r); check("R3 N flag is bit 5", r, 32'h8000_0070);
        bus_write(OFS_D, 32'h0000_01FF);
        bus_read(OFS_D, r);   check("R2 D masked readback", r, 32'h1FF & MND_MASK);
        bus_read(OFS_CMD, r); check("R3 D flag is bit 7", r, 32'h8000_00F0);
        check("R2 active unchanged by shadow writes", act_word(), 0);
    endtask

    task automatic t_commit();
        logic [31:0] r;
        bus_write(OFS_CMD, 32'h0000_0001);
        for (int k = 0; k < int'(COMMIT_CYCLES); k++) begin
            bus_read(OFS_CMD, r);
            check("R4 update bit high during commit", 32'(r[0]), 1);
            check("R4 active held until completion", act_word(), 0);
            @(negedge clk);
        end
        bus_read(OFS_CMD, r);
        check("R4 update bit cleared, R5 flags cleared", r, 32'h8000_0000);
        check("R4 active set loaded at once", act_word(), mk_act(5'h1F, 3'h7, 2'h3, 8'h34, 8'hCD, 8'hFF));
    endtask

    task automatic t_same_value();
        logic [31:0] r;
        bus_write(OFS_M, 32'h0000_0034);
        bus_read(OFS_CMD, r); check("R3 equal write leaves M flag clear", r, 32'h8000_0000);
        bus_write(OFS_CFG, 32'h0000_371F);
        bus_read(OFS_CMD, r); check("R3 equal write leaves cfg flag clear", r, 32'h8000_0000);
        bus_write(OFS_CFG, 32'hC8E0_771F);
        bus_read(OFS_CMD, r); check("R3 unimplemented-bit change leaves flag clear", r, 32'h8000_0000);
        bus_write(OFS_N, 32'h0000_0100);
        bus_read(OFS_CMD, r); check("R3 masked change sets N flag", r, 32'h8000_0020);
    endtask

    task automatic t_no_cancel();
        int s, el;
        bus_write(OFS_CMD, 32'h0000_0001);
        s = cyc;
        bus_write(OFS_CMD, 32'h0000_0000);
        bus_write(OFS_CMD, 32'h0000_0001);
        wait_clear(s, el);
        check("R6 completion time unchanged by cancel/restart writes", 32'(el), 32'(COMMIT_CYCLES));
        check("R6 commit still applied N", 32'(act_n_o), 32'h00);
    endtask

    task automatic t_write_at_done();
        logic [31:0] r;
        int s, el;
        bus_write(OFS_M, 32'h0000_0077);
        bus_write(OFS_CMD, 32'h0000_0001);
        s = cyc;
        repeat (COMMIT_CYCLES - 2) @(negedge clk);
        bus_write(OFS_D, 32'h0000_0042); // lands on the completion edge
        bus_read(OFS_CMD, r);
        check("R5 write on completion edge keeps D flag only", r, 32'h8000_0080);
        check("R5 M committed", 32'(act_m_o), 32'h77);
        check("R5 late D write not committed", 32'(act_d_o), 32'hFF);
        bus_read(OFS_D, r); check("R5 late D write staged", r, 32'h42);
        bus_write(OFS_CMD, 32'h0000_0001);
        s = cyc;
        wait_clear(s, el);
        check("R4 second commit latency", 32'(el), 32'(COMMIT_CYCLES));
        check("R4 D committed by second commit", 32'(act_d_o), 32'h42);
    endtask

    task automatic t_root();
        logic [31:0] r;
        bus_write(OFS_CMD, 32'h0000_0002);
        bus_read(OFS_CMD, r); check("R7 enable set, running, bit 31 low", r, 32'h0000_0002);
        check("R7 enable output immediate", 32'(root_en_o), 1);
        clk_running_i = 1'b0;
        bus_read(OFS_CMD, r); check("R7 stopped clock sets bit 31", r, 32'h8000_0002);
        clk_running_i = 1'b1;
        bus_write(OFS_CMD, 32'h0000_0000);
        bus_read(OFS_CMD, r); check("R7 enable cleared sets bit 31", r, 32'h8000_0000);
        check("R7 enable output cleared", 32'(root_en_o), 0);
        bus_write(OFS_CMD, 32'h0000_0002);
    endtask

    task automatic t_ignored();
        logic [31:0] r;
        bus_write(OFS_CFG, 32'h0000_0005);
        bus_write(OFS_CMD, 32'hFFFF_FF02);
        bus_read(OFS_CMD, r); check("R8 ones to flag bits do nothing", r, 32'h0000_0012);
        bus_write(OFS_CMD, 32'h0000_0002);
        bus_read(OFS_CMD, r); check("R8 zeros to flag bits do nothing", r, 32'h0000_0012);
        bus_write(32'h14, 32'h0000_DEAD);
        bus_write(32'h06, 32'h0000_0003);
        bus_read(32'h14, r);  check("R8 unmapped read is zero", r, 0);
        bus_read(32'h1C, r);  check("R8 unmapped read is zero", r, 0);
        bus_read(OFS_CFG, r); check("R8 unmapped writes leave cfg", r, 32'h0000_0005);
        bus_read(OFS_CMD, r); check("R8 unmapped writes leave flags", r, 32'h0000_0012);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shadow();
        t_commit();
        t_same_value();
        t_no_cancel();
        t_write_at_done();
        t_root();
        t_ignored();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule